// File: doc/BRIEF.md
# Branch Source Class Decoder

This block labels a recorded control-flow change with a class mask. Its inputs are the leading opcode bytes found at the branch source, the ModRM byte that follows the opcode, and the source and target addresses of the change. A profiling filter downstream compares the mask against a set of wanted classes and discards records that do not match. The block compares each address against a kernel-space boundary, which is a parameter, to find the privilege level of that address. It then decodes the opcode bytes into one branch class.

User-to-kernel transitions get special treatment. A transfer from user space into kernel space is relabelled as a hardware interrupt or fault unless the opcode is a system call or a software interrupt. The privilege level of the target is then merged into the mask. If either address is zero, the record has not been filled in yet, and the result is the empty mask.

A valid input is registered once. Its mask appears on the output one clock later, together with an output valid flag.

Top module: `branch_class_unit`

## Requirements
- R1: The output mask has twelve bits. Bit 0 means user target and bit 1 means kernel target. The class bits are: call bit 2, return bit 3, system call bit 4, system return bit 5, software interrupt bit 6, interrupt return bit 7, conditional bit 8, jump bit 9, hardware interrupt/fault bit 10, indirect call bit 11. The empty mask 0 means no class. At most one class bit and at most one privilege bit are ever set.
- R2: When the first byte is the escape 0x0F, the second byte decides the class. 0x05 and 0x34 give system call, 0x07 and 0x35 give system return, and 0x80 through 0x8F give conditional. Any other second byte gives no class.
- R3: First bytes 0x70–0x7F and 0xE0–0xE3 give conditional. First bytes 0xE9–0xEB give jump. First bytes 0xE8 and 0x9A give call.
- R4: First bytes 0xC2, 0xC3, 0xCA and 0xCB give return. 0xCF gives interrupt return. 0xCC–0xCE give software interrupt.
- R5: For first byte 0xFF the decoder looks at ModRM bits [5:3]. A value of 2 or 3 gives indirect call, 4 or 5 gives jump, and any other value gives no class.
- R6: If the source address or the target address is zero, the result is the empty mask, whatever the opcode.
- R7: Suppose the source is user, the target is kernel and neither address is zero. The class is then hardware interrupt/fault (mask 0x402), unless the decoded class is system call or software interrupt. This also applies when the opcode decodes to no class.
- R8: An address is kernel when it is at or above the parameter KERNEL_BASE, and user otherwise. When the class is not empty, the target privilege bit is ORed into the mask.
- R9: out_valid and out_class are updated on the clock edge that samples in_valid. A cycle without in_valid gives out_valid 0 and out_class 0, and so does reset.
- R10: Any opcode not listed in R2–R5 gives the empty mask, unless R7 applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Inputs carry a record to classify |
| op_byte0 | input | 8 | First opcode byte at the source |
| op_byte1 | input | 8 | Byte after the first (used after escape 0x0F) |
| modrm_byte | input | 8 | ModRM byte following opcode 0xFF |
| src_addr | input | AW | Source address of the control-flow change |
| dst_addr | input | AW | Target address of the control-flow change |
| out_valid | output | 1 | out_class holds a fresh result |
| out_class | output | 12 | Class mask with target privilege bit |

## Verification
Every result is due exactly one clock edge after the edge that samples in_valid high. The following idle edge clears the result back to zero. The bench drives inputs on the falling edge and samples on the next falling edge, which falls between the capturing edge and the one that follows it. Back-to-back inputs are checked on successive falling edges to confirm that each record gets its own slot. The idle clear is checked on the falling edge after that.

// File: rtl/bcu_pkg.sv
package bcu_pkg;

  localparam int CLS_W = 12;

  typedef enum int {
    B_USER    = 0,
    B_KERNEL  = 1,
    B_CALL    = 2,
    B_RET     = 3,
    B_SYSCALL = 4,
    B_SYSRET  = 5,
    B_SWINT   = 6,
    B_IRET    = 7,
    B_COND    = 8,
    B_JUMP    = 9,
    B_HWIRQ   = 10,
    B_INDCALL = 11
  } cls_bit_e;

  typedef logic [CLS_W-1:0] cls_mask_t;

  function automatic cls_mask_t bit_of(cls_bit_e b);
    return cls_mask_t'(1) << int'(b);
  endfunction

  function automatic logic in_span(logic [7:0] v, logic [7:0] lo, logic [7:0] hi);
    return (v >= lo) && (v <= hi);
  endfunction

  // second byte after the 0x0F escape
  function automatic cls_mask_t decode_escape(logic [7:0] b1);
    cls_mask_t r;
    r = '0;
    if (b1 == 8'h05 || b1 == 8'h34)      r = bit_of(B_SYSCALL);
    else if (b1 == 8'h07 || b1 == 8'h35) r = bit_of(B_SYSRET);
    else if (in_span(b1, 8'h80, 8'h8F))  r = bit_of(B_COND);
    return r;
  endfunction

  // group opcode 0xFF: class chosen by the ModRM reg field
  function automatic cls_mask_t decode_group(logic [2:0] reg_f);
    cls_mask_t r;
    case (reg_f)
      3'd2, 3'd3: r = bit_of(B_INDCALL);
      3'd4, 3'd5: r = bit_of(B_JUMP);
      default:    r = '0;
    endcase
    return r;
  endfunction

  function automatic cls_mask_t decode_first(logic [7:0] b0, logic [7:0] b1,
                                             logic [2:0] reg_f);
    cls_mask_t r;
    case (b0)
      8'h0F:                      r = decode_escape(b1);
      8'hC2, 8'hC3, 8'hCA, 8'hCB: r = bit_of(B_RET);
      8'hCF:                      r = bit_of(B_IRET);
      8'hCC, 8'hCD, 8'hCE:        r = bit_of(B_SWINT);
      8'hE8, 8'h9A:               r = bit_of(B_CALL);
      8'hE9, 8'hEA, 8'hEB:        r = bit_of(B_JUMP);
      8'hFF:                      r = decode_group(reg_f);
      default:
        if (in_span(b0, 8'h70, 8'h7F) || in_span(b0, 8'hE0, 8'hE3))
          r = bit_of(B_COND);
        else
          r = '0;
    endcase
    return r;
  endfunction

  // ring-entry relabel and privilege merge
  function automatic cls_mask_t merge_priv(cls_mask_t raw, logic src_k,
                                           logic dst_k, logic any_zero);
    cls_mask_t c;
    logic exempt;
    exempt = (raw == bit_of(B_SYSCALL)) || (raw == bit_of(B_SWINT));
    c = (!src_k && dst_k && !exempt) ? bit_of(B_HWIRQ) : raw;
    if (any_zero || c == '0) return '0;
    return c | (dst_k ? bit_of(B_KERNEL) : bit_of(B_USER));
  endfunction

endpackage

// File: rtl/bcu_priv_cmp.sv
module bcu_priv_cmp #(
  parameter int          AW          = 48,
  parameter logic [AW-1:0] KERNEL_BASE = {1'b1, {(AW-1){1'b0}}}
) (
  input  logic [AW-1:0] addr,
  output logic          is_kernel,
  output logic          is_zero
);
  assign is_kernel = (addr >= KERNEL_BASE);
  assign is_zero   = (addr == '0);
endmodule

// File: rtl/bcu_opcode_decode.sv
module bcu_opcode_decode
  import bcu_pkg::*;
(
  input  logic [7:0] byte0,
  input  logic [7:0] byte1,
  input  logic [7:0] modrm,
  output cls_mask_t  raw_cls
);
  logic [2:0] reg_field;
  logic       modrm_unused;

  assign reg_field    = modrm[5:3];
  assign modrm_unused = ^{modrm[7:6], modrm[2:0]};
  assign raw_cls      = decode_first(byte0, byte1, reg_field);
endmodule

// File: rtl/bcu_class_merge.sv
module bcu_class_merge
  import bcu_pkg::*;
(
  input  cls_mask_t raw_cls,
  input  logic      src_kernel,
  input  logic      dst_kernel,
  input  logic      any_zero,
  output logic      ring_entry,
  output cls_mask_t final_cls
);
  assign ring_entry = !src_kernel && dst_kernel;
  assign final_cls  = merge_priv(raw_cls, src_kernel, dst_kernel, any_zero);
endmodule

// File: rtl/branch_class_unit.sv
module branch_class_unit
  import bcu_pkg::*;
#(
  parameter int            AW          = 48,
  parameter logic [AW-1:0] KERNEL_BASE = {1'b1, {(AW-1){1'b0}}}
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [7:0]           op_byte0,
  input  logic [7:0]           op_byte1,
  input  logic [7:0]           modrm_byte,
  input  logic [AW-1:0]        src_addr,
  input  logic [AW-1:0]        dst_addr,
  output logic                 out_valid,
  output logic [CLS_W-1:0]     out_class
);
  localparam int NADDR = 2;

  logic [AW-1:0] addr_vec [NADDR];
  logic [NADDR-1:0] kern_vec;
  logic [NADDR-1:0] zero_vec;

  logic      src_is_kernel;
  logic      dst_is_kernel;
  logic      addr_zero;
  logic      ring_entry;
  cls_mask_t raw_cls;
  cls_mask_t next_cls;

  assign addr_vec[0] = src_addr;
  assign addr_vec[1] = dst_addr;

  for (genvar g = 0; g < NADDR; g++) begin : g_priv
    bcu_priv_cmp #(.AW(AW), .KERNEL_BASE(KERNEL_BASE)) u_cmp (
      .addr      (addr_vec[g]),
      .is_kernel (kern_vec[g]),
      .is_zero   (zero_vec[g])
    );
  end

  assign src_is_kernel = kern_vec[0];
  assign dst_is_kernel = kern_vec[1];
  assign addr_zero     = |zero_vec;

  bcu_opcode_decode u_dec (
    .byte0   (op_byte0),
    .byte1   (op_byte1),
    .modrm   (modrm_byte),
    .raw_cls (raw_cls)
  );

  bcu_class_merge u_merge (
    .raw_cls    (raw_cls),
    .src_kernel (src_is_kernel),
    .dst_kernel (dst_is_kernel),
    .any_zero   (addr_zero),
    .ring_entry (ring_entry),
    .final_cls  (next_cls)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_class <= '0;
    end else begin
      out_valid <= in_valid;
      out_class <= in_valid ? next_cls : '0;
    end
  end
endmodule

// File: rtl/bcu_checker.sv
module bcu_checker
  import bcu_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             out_valid,
  input logic [CLS_W-1:0] out_class,
  input cls_mask_t        raw_cls,
  input logic             src_is_kernel,
  input logic             dst_is_kernel,
  input logic             addr_zero,
  input logic             ring_entry
);
  localparam cls_mask_t SYSC  = 12'h010;
  localparam cls_mask_t SWI   = 12'h040;
  localparam cls_mask_t IRQ_K = 12'h402;

  p_class_shape_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($onehot0(out_class[11:2]) && $onehot0(out_class[1:0])));

  p_zero_none_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && addr_zero) |=> (out_class == '0));

  p_ring_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !addr_zero && ring_entry && raw_cls != SYSC && raw_cls != SWI)
      |=> (out_class == IRQ_K));

  p_priv_merge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !addr_zero && raw_cls != '0)
      |=> (out_class[1] == $past(dst_is_kernel) && out_class[0] == !$past(dst_is_kernel)));

  p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && out_class == '0));

  p_unknown_none_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !addr_zero && raw_cls == '0 && !(!src_is_kernel && dst_is_kernel))
      |=> (out_class == '0));
endmodule

bind branch_class_unit bcu_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .out_valid     (out_valid),
  .out_class     (out_class),
  .raw_cls       (raw_cls),
  .src_is_kernel (src_is_kernel),
  .dst_is_kernel (dst_is_kernel),
  .addr_zero     (addr_zero),
  .ring_entry    (ring_entry)
);

// File: tb/branch_class_unit_tb.sv
`timescale 1ns/1ps
module branch_class_unit_tb;
  localparam int          AW    = 48;
  localparam logic [47:0] KBASE = 48'h8000_0000_0000;
  localparam int          NV    = 52;

  // {op0, op1, modrm, src code, dst code, expected}
  // address codes: 0 zero, 1 user, 2 kernel, 3 exactly KBASE (kernel)
  localparam logic [39:0] VEC [NV] = '{
    // R2 escape
    {8'h0F,8'h05,8'h00,2'd1,2'd1,12'h011},
    {8'h0F,8'h34,8'h00,2'd1,2'd2,12'h012},
    {8'h0F,8'h07,8'h00,2'd2,2'd1,12'h021},
    {8'h0F,8'h35,8'h00,2'd2,2'd1,12'h021},
    {8'h0F,8'h80,8'h00,2'd1,2'd1,12'h101},
    {8'h0F,8'h8F,8'h00,2'd2,2'd2,12'h102},
    {8'h0F,8'h90,8'h00,2'd1,2'd1,12'h000},
    {8'h0F,8'h7F,8'h00,2'd1,2'd1,12'h000},
    {8'h0F,8'h06,8'h00,2'd2,2'd2,12'h000},
    // R3 single-byte
    {8'h70,8'h00,8'h00,2'd1,2'd1,12'h101},
    {8'h7F,8'h00,8'h00,2'd2,2'd2,12'h102},
    {8'hE0,8'h00,8'h00,2'd1,2'd1,12'h101},
    {8'hE3,8'h00,8'h00,2'd2,2'd2,12'h102},
    {8'hE9,8'h00,8'h00,2'd1,2'd1,12'h201},
    {8'hEA,8'h00,8'h00,2'd1,2'd1,12'h201},
    {8'hEB,8'h00,8'h00,2'd2,2'd2,12'h202},
    {8'hE8,8'h00,8'h00,2'd1,2'd1,12'h005},
    {8'h9A,8'h00,8'h00,2'd2,2'd2,12'h006},
    {8'h6F,8'h00,8'h00,2'd1,2'd1,12'h000},
    {8'hE4,8'h00,8'h00,2'd1,2'd1,12'h000},
    // R4 returns and interrupts
    {8'hC2,8'h00,8'h00,2'd2,2'd1,12'h009},
    {8'hC3,8'h00,8'h00,2'd1,2'd1,12'h009},
    {8'hCA,8'h00,8'h00,2'd2,2'd2,12'h00A},
    {8'hCB,8'h00,8'h00,2'd2,2'd1,12'h009},
    {8'hCF,8'h00,8'h00,2'd2,2'd1,12'h081},
    {8'hCC,8'h00,8'h00,2'd1,2'd2,12'h042},
    {8'hCD,8'h00,8'h00,2'd1,2'd1,12'h041},
    {8'hCE,8'h00,8'h00,2'd2,2'd2,12'h042},
    // R5 group 0xFF
    {8'hFF,8'h00,8'h10,2'd1,2'd1,12'h801},
    {8'hFF,8'h00,8'h18,2'd2,2'd2,12'h802},
    {8'hFF,8'h00,8'h20,2'd1,2'd1,12'h201},
    {8'hFF,8'h00,8'h28,2'd2,2'd2,12'h202},
    {8'hFF,8'h00,8'h00,2'd1,2'd1,12'h000},
    {8'hFF,8'h00,8'h38,2'd2,2'd2,12'h000},
    {8'hFF,8'h00,8'hD7,2'd1,2'd1,12'h801},
    {8'hFF,8'h00,8'h30,2'd1,2'd1,12'h000},
    // R10 unknown
    {8'h90,8'h00,8'h00,2'd1,2'd1,12'h000},
    {8'hC1,8'h00,8'h00,2'd2,2'd2,12'h000},
    {8'h90,8'h00,8'h00,2'd2,2'd1,12'h000},
    // R7 ring entry
    {8'h90,8'h00,8'h00,2'd1,2'd2,12'h402},
    {8'hE8,8'h00,8'h00,2'd1,2'd2,12'h402},
    {8'hC3,8'h00,8'h00,2'd1,2'd2,12'h402},
    {8'hFF,8'h00,8'h10,2'd1,2'd2,12'h402},
    {8'h0F,8'h07,8'h00,2'd1,2'd2,12'h402},
    {8'h0F,8'h05,8'h00,2'd1,2'd3,12'h012},
    // R8 boundary address counts as kernel
    {8'hE9,8'h00,8'h00,2'd3,2'd3,12'h202},
    {8'hCF,8'h00,8'h00,2'd3,2'd1,12'h081},
    // R6 zero addresses
    {8'hE8,8'h00,8'h00,2'd0,2'd1,12'h000},
    {8'hE8,8'h00,8'h00,2'd1,2'd0,12'h000},
    {8'h0F,8'h05,8'h00,2'd0,2'd2,12'h000},
    {8'h90,8'h00,8'h00,2'd0,2'd2,12'h000},
    {8'hCC,8'h00,8'h00,2'd2,2'd0,12'h000}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [7:0]    b0, b1, rm;
  logic [AW-1:0] sa, da;
  logic          out_valid;
  logic [11:0]   out_class;

  int n_run  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  branch_class_unit #(.AW(AW), .KERNEL_BASE(KBASE)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .op_byte0   (b0),
    .op_byte1   (b1),
    .modrm_byte (rm),
    .src_addr   (sa),
    .dst_addr   (da),
    .out_valid  (out_valid),
    .out_class  (out_class)
  );

  function automatic logic [AW-1:0] addr_of(logic [1:0] code);
    case (code)
      2'd0:    return '0;
      2'd1:    return 48'h0000_0040_1000;
      2'd2:    return KBASE + 48'h1234;
      default: return KBASE;
    endcase
  endfunction

  function automatic string req_of(logic [7:0] op, logic [1:0] s, logic [1:0] d);
    if (s == 2'd0 || d == 2'd0) return "R6";
    if (s == 2'd1 && d != 2'd1) return "R7";
    if (s == 2'd3 || d == 2'd3) return "R8";
    if (op == 8'h0F) return "R2";
    if (op == 8'hFF) return "R5";
    if (op >= 8'hC2 && op <= 8'hCF) return "R4";
    if ((op >= 8'h70 && op <= 8'h7F) || (op >= 8'hE0 && op <= 8'hEB) || op == 8'h9A)
      return "R3";
    return "R10";
  endfunction

  task automatic check(string req, logic v_act, logic v_exp,
                       logic [11:0] c_act, logic [11:0] c_exp);
    n_run++;
    if (v_act !== v_exp || c_act !== c_exp) begin
      n_fail++;
      $display("FAIL %s: valid=%0b class=%03h, expected valid=%0b class=%03h",
               req, v_act, c_act, v_exp, c_exp);
    end
  endtask

  task automatic drive(logic [7:0] o0, logic [7:0] o1, logic [7:0] m,
                       logic [AW-1:0] s, logic [AW-1:0] d);
    b0 = o0; b1 = o1; rm = m; sa = s; da = d; in_valid = 1'b1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0;
    b0 = '0; b1 = '0; rm = '0; sa = '0; da = '0;
    repeat (3) @(negedge clk);
    check("R9 reset", out_valid, 1'b0, out_class, 12'h000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 idle after reset", out_valid, 1'b0, out_class, 12'h000);

    // table walk: drive on a falling edge, result due after the next rising edge
    for (int i = 0; i < NV; i++) begin
      logic [39:0] v;
      v = VEC[i];
      drive(v[39:32], v[31:24], v[23:16], addr_of(v[15:14]), addr_of(v[13:12]));
      @(negedge clk);
      in_valid = 1'b0;
      check(req_of(v[39:32], v[15:14], v[13:12]), out_valid, 1'b1, out_class, v[11:0]);
    end

    // R8 address just below the boundary is user
    drive(8'hE8, 8'h00, 8'h00, 48'h0000_0040_1000, KBASE - 48'd1);
    @(negedge clk); in_valid = 1'b0;
    check("R8 below boundary", out_valid, 1'b1, out_class, 12'h005);
    drive(8'hE8, 8'h00, 8'h00, 48'h0000_0040_1000, KBASE);
    @(negedge clk); in_valid = 1'b0;
    check("R7 exact boundary target", out_valid, 1'b1, out_class, 12'h402);

    // R9 back-to-back records, then idle clears
    drive(8'hCF, 8'h00, 8'h00, KBASE + 48'h10, 48'h0000_0000_2000);
    @(negedge clk);
    check("R9 first of pair", out_valid, 1'b1, out_class, 12'h081);
    drive(8'h74, 8'h00, 8'h00, KBASE + 48'h10, KBASE + 48'h20);
    @(negedge clk);
    check("R9 second of pair", out_valid, 1'b1, out_class, 12'h102);
    in_valid = 1'b0;
    @(negedge clk);
    check("R9 idle clears", out_valid, 1'b0, out_class, 12'h000);

    // R9 inputs without in_valid have no effect
    b0 = 8'hE8; sa = 48'h1000; da = 48'h2000;
    @(negedge clk);
    check("R9 ignored without valid", out_valid, 1'b0, out_class, 12'h000);

    // R9 reset mid-stream clears a pending result
    drive(8'hE8, 8'h00, 8'h00, 48'h1000, 48'h2000);
    rst_n = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 reset overrides", out_valid, 1'b0, out_class, 12'h000);
    rst_n = 1'b1;
    @(negedge clk);

    finish_run();
  end
endmodule